// File: doc/BRIEF.md
# Product Term Steering and Sharing Matrix

This block routes the general-purpose product terms of one programmable logic block to that block's macrocells. Each macrocell has an enable mask over the term vector. The macrocell's sum output is the OR of the product terms its mask selects. A macrocell can take no terms at all, or up to a fixed maximum. One term can feed several macrocells at once, which lets a common term be built only once and used by many outputs. Sharing is limited to a window of four neighbouring macrocells around the term's home position.

The masks arrive over a serial shift port into a shadow register, and a load strobe commits them. At commit time each mask is checked against its macrocell's window and against the term limit. Bits that break a rule are dropped and a single error flag is raised. The committed, pruned masks then drive a plain AND-OR plane. The sum path therefore has the same depth whatever configuration is loaded.

Top module: `ptam_matrix`

## Requirements
- R1: While reset is asserted and after it is released, every `sum_out` bit is 0 and `config_error` is 0, for any `pt_in`, until the first load strobe.
- R2: Configuration bits enter on `cfg_sdi`, one bit per clock with `cfg_shift` high, first bit first. After NUM_MC*NUM_TERMS shifts, the first bit sent sits at index 0. Bit index m*NUM_TERMS+t enables term t for macrocell m. Shifting alone changes neither `sum_out` nor `config_error`.
- R3: From the clock edge where `cfg_load` is high, the shadow contents become the active configuration. After that, `sum_out[m]` is the OR of `pt_in[t]` over the terms kept for macrocell m. `sum_out` follows `pt_in` combinationally, with no register in between.
- R4: A macrocell whose mask is all zero drives a constant 0 on its `sum_out` bit, and this is not an error.
- R5: Term t has home index h = t / TERMS_PER_MC. It may feed macrocell m only if m-2 <= h <= m+1. A set mask bit outside this window sets `config_error` and has no effect on `sum_out[m]`.
- R6: A mask with more than MAX_TERMS bits set sets `config_error`. Only the MAX_TERMS lowest-indexed legal enabled terms enter the sum.
- R7: A term enabled in the masks of several macrocells drives the sum of each of them.
- R8: `config_error` is updated only on a load strobe. A load with no rule broken clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift one configuration bit into the shadow register |
| cfg_load | input | 1 | Commit the shadow configuration to the active masks |
| pt_in | input | NUM_TERMS | Product term values |
| sum_out | output | NUM_MC | Per-macrocell OR of the kept terms |
| config_error | output | 1 | Last committed configuration broke a window or count rule |

## Verification
The bench builds the block with four macrocells, three terms per home slot (twelve terms) and a limit of four terms per macrocell. With 48 configuration bits, every one of the 4096 term vectors can be swept after each load. The edge macrocells get clipped windows, the middle macrocell reaches every term, and the limit of four is easy to exceed. Hand-picked masks cover the empty, shared, out-of-window and over-limit cases. Random masks mix these rules together.

// File: rtl/ptam_pkg.sv
// Shared constants and helpers for the product term allocator matrix.
// Assumes term t has home slot t / TERMS_PER_MC and that the sharing window
// spans four adjacent macrocells: home-1 up to home+2.
package ptam_pkg;
    localparam int unsigned WIN_BACK = 2;  // macrocell may reach homes down to m-2
    localparam int unsigned WIN_FWD  = 1;  // and up to m+1

    // True when term 'term' is allowed to feed macrocell 'mc'.
    function automatic logic term_legal(input int unsigned mc,
                                        input int unsigned term,
                                        input int unsigned tpm);
        int unsigned home;
        home = term / tpm;
        return ((home + WIN_BACK) >= mc) && (home <= (mc + WIN_FWD));
    endfunction
endpackage

// File: rtl/ptam_shadow.sv
// Serial shadow register for the allocator configuration.
// Bits enter at the top and move toward index 0, so the first bit sent
// ends at index 0 after CFG_BITS shifts. Assumes a synchronous active-low reset.
module ptam_shadow #(
    parameter int unsigned CFG_BITS = 1280
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdi,
    input  logic                shift,
    output logic [CFG_BITS-1:0] q
);
    // Shift one bit in per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (shift)
            q <= {sdi, q[CFG_BITS-1:1]};
    end
endmodule

// File: rtl/ptam_prune.sv
// Rule check and pruning for one macrocell's raw mask.
// Drops bits outside the macrocell's sharing window and keeps at most
// MAX_TERMS of the remaining ones, lowest index first. Flags any broken rule.
// Purely combinational; it sits on the load path only, never on the sum path.
module ptam_prune #(
    parameter int unsigned NUM_TERMS    = 80,
    parameter int unsigned TERMS_PER_MC = 5,
    parameter int unsigned MC_IDX       = 0,
    parameter int unsigned MAX_TERMS    = 16
) (
    input  logic [NUM_TERMS-1:0] raw,
    output logic [NUM_TERMS-1:0] kept,
    output logic                 err
);
    import ptam_pkg::*;

    localparam int unsigned CW = $clog2(NUM_TERMS + 1);

    logic [NUM_TERMS-1:0] legal;
    logic                 outside;
    logic                 too_many;

    // Window mask for this macrocell.
    always_comb begin
        for (int unsigned t = 0; t < NUM_TERMS; t++)
            legal[t] = term_legal(MC_IDX, t, TERMS_PER_MC);
    end

    // Keep the lowest legal terms up to the limit and count every set bit.
    always_comb begin
        logic [CW-1:0] n_legal;
        logic [CW-1:0] n_all;
        n_legal = '0;
        n_all   = '0;
        kept    = '0;
        for (int unsigned t = 0; t < NUM_TERMS; t++) begin
            if (raw[t])
                n_all = n_all + 1'b1;
            if (raw[t] && legal[t]) begin
                if (n_legal < CW'(MAX_TERMS))
                    kept[t] = 1'b1;
                n_legal = n_legal + 1'b1;
            end
        end
        too_many = (n_all > CW'(MAX_TERMS));
    end

    // Any set bit outside the window is a rule break.
    assign outside = |(raw & ~legal);
    assign err     = outside | too_many;
endmodule

// File: rtl/ptam_or_plane.sv
// Fixed-depth AND-OR sum for one macrocell.
// Depth depends only on NUM_TERMS, not on how many mask bits are set.
module ptam_or_plane #(
    parameter int unsigned NUM_TERMS = 80
) (
    input  logic [NUM_TERMS-1:0] pt,
    input  logic [NUM_TERMS-1:0] mask,
    output logic                 sum
);
    // Gate each term by its enable and reduce with a balanced OR.
    assign sum = |(pt & mask);
endmodule

// File: rtl/ptam_matrix.sv
// Product term allocator matrix for one logic block.
// Assumes the configuration is shifted in while cfg_load is low. A load in
// the same cycle as a shift commits the shadow value from before that shift.
// The active masks are pruned at load time, so the sum path is AND-OR only.
module ptam_matrix #(
    parameter int unsigned NUM_MC       = 16,
    parameter int unsigned TERMS_PER_MC = 5,
    parameter int unsigned MAX_TERMS    = 16,
    localparam int unsigned NUM_TERMS   = NUM_MC * TERMS_PER_MC,
    localparam int unsigned CFG_BITS    = NUM_MC * NUM_TERMS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_sdi,
    input  logic                 cfg_shift,
    input  logic                 cfg_load,
    input  logic [NUM_TERMS-1:0] pt_in,
    output logic [NUM_MC-1:0]    sum_out,
    output logic                 config_error
);
    logic [CFG_BITS-1:0] shadow_q;
    logic [CFG_BITS-1:0] kept_flat;
    logic [CFG_BITS-1:0] active_flat;
    logic [NUM_MC-1:0]   mc_err;

    ptam_shadow #(.CFG_BITS(CFG_BITS)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .sdi   (cfg_sdi),
        .shift (cfg_shift),
        .q     (shadow_q)
    );

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        ptam_prune #(
            .NUM_TERMS   (NUM_TERMS),
            .TERMS_PER_MC(TERMS_PER_MC),
            .MC_IDX      (m),
            .MAX_TERMS   (MAX_TERMS)
        ) u_prune (
            .raw  (shadow_q[m*NUM_TERMS +: NUM_TERMS]),
            .kept (kept_flat[m*NUM_TERMS +: NUM_TERMS]),
            .err  (mc_err[m])
        );

        ptam_or_plane #(.NUM_TERMS(NUM_TERMS)) u_or (
            .pt   (pt_in),
            .mask (active_flat[m*NUM_TERMS +: NUM_TERMS]),
            .sum  (sum_out[m])
        );
    end

    // Commit the pruned masks and the rule flag on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_flat  <= '0;
            config_error <= 1'b0;
        end else if (cfg_load) begin
            active_flat  <= kept_flat;
            config_error <= |mc_err;
        end
    end
endmodule

// File: rtl/ptam_checker.sv
// Property checker for ptam_matrix, attached with bind below.
// Observes the ports and the committed mask vector of the matrix.
module ptam_checker #(
    parameter int unsigned NUM_MC       = 16,
    parameter int unsigned TERMS_PER_MC = 5,
    parameter int unsigned MAX_TERMS    = 16,
    localparam int unsigned NUM_TERMS   = NUM_MC * TERMS_PER_MC
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_load,
    input logic [NUM_TERMS-1:0]        pt_in,
    input logic [NUM_MC-1:0]           sum_out,
    input logic                        config_error,
    input logic [NUM_MC*NUM_TERMS-1:0] active_flat
);
    import ptam_pkg::*;

    AST_ERR_ON_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(config_error)); // R8

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(pt_in) -> $stable(sum_out))); // R2

    for (genvar m = 0; m < NUM_MC; m++) begin : g_chk
        logic [NUM_TERMS-1:0] win;
        logic [NUM_TERMS-1:0] act;

        // Window of legal terms for this macrocell.
        always_comb begin
            for (int unsigned t = 0; t < NUM_TERMS; t++)
                win[t] = term_legal(m, t, TERMS_PER_MC);
        end
        assign act = active_flat[m*NUM_TERMS +: NUM_TERMS];

        AST_EMPTY_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (act == '0) |-> !sum_out[m]); // R4

        AST_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            (act & ~win) == '0); // R5

        AST_TERM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(act) <= MAX_TERMS); // R6
    end
endmodule

bind ptam_matrix ptam_checker #(
    .NUM_MC      (NUM_MC),
    .TERMS_PER_MC(TERMS_PER_MC),
    .MAX_TERMS   (MAX_TERMS)
) u_ptam_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .pt_in        (pt_in),
    .sum_out      (sum_out),
    .config_error (config_error),
    .active_flat  (active_flat)
);

// File: tb/tb_ptam_matrix.sv
`timescale 1ns/1ps
module tb_ptam_matrix;
    localparam int MC  = 4;
    localparam int TPM = 3;
    localparam int MX  = 4;
    localparam int NT  = MC * TPM;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_sdi = 1'b0;
    logic          cfg_shift = 1'b0;
    logic          cfg_load = 1'b0;
    logic [NT-1:0] pt_in = '0;
    logic [MC-1:0] sum_out;
    logic          config_error;

    int checks = 0;
    int fails  = 0;
    logic [NT-1:0] mask [MC];   // committed configuration model
    logic [NT-1:0] pend [MC];   // shifted but not yet committed

    ptam_matrix #(.NUM_MC(MC), .TERMS_PER_MC(TPM), .MAX_TERMS(MX)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_sdi(cfg_sdi), .cfg_shift(cfg_shift),
        .cfg_load(cfg_load), .pt_in(pt_in), .sum_out(sum_out),
        .config_error(config_error)
    );

    always #4 clk = ~clk;

    function automatic bit legal(int m, int t);
        int h = t / TPM;
        return (h + 2 >= m) && (h <= m + 1);
    endfunction

    function automatic logic [MC-1:0] exp_sum(logic [NT-1:0] p);
        logic [MC-1:0] r = '0;
        for (int m = 0; m < MC; m++) begin
            int n = 0;
            for (int t = 0; t < NT; t++)
                if (mask[m][t] && legal(m, t)) begin
                    if (n < MX) r[m] = r[m] | p[t];
                    n++;
                end
        end
        return r;
    endfunction

    function automatic bit exp_err();
        bit e = 0;
        for (int m = 0; m < MC; m++) begin
            if ($countones(mask[m]) > MX) e = 1;
            for (int t = 0; t < NT; t++)
                if (mask[m][t] && !legal(m, t)) e = 1;
        end
        return e;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Shift all masks in pend[] serially, index 0 first; optional commit.
    task automatic send(bit commit);
        for (int i = 0; i < MC * NT; i++) begin
            cfg_sdi   = pend[i / NT][i % NT];
            cfg_shift = 1'b1;
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        if (commit) begin
            cfg_load = 1'b1;
            @(negedge clk);
            cfg_load = 1'b0;
            for (int m = 0; m < MC; m++) mask[m] = pend[m];
        end
    endtask

    task automatic apply(logic [NT-1:0] a, logic [NT-1:0] b,
                         logic [NT-1:0] c, logic [NT-1:0] d);
        pend[0] = a; pend[1] = b; pend[2] = c; pend[3] = d;
        send(1'b1);
    endtask

    // Sweep every term vector and compare the sums; then the flag.
    task automatic sweep(string tag);
        int bad = 0;
        for (int p = 0; p < (1 << NT); p++) begin
            pt_in = NT'(p);
            #1;
            if (sum_out !== exp_sum(NT'(p))) begin
                if (bad == 0) chk(tag, 32'(sum_out), 32'(exp_sum(NT'(p))));
                bad++;
            end
        end
        if (bad == 0) checks++;
        chk({tag, " flag"}, 32'(config_error), 32'(exp_err()));
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        for (int m = 0; m < MC; m++) begin mask[m] = '0; pend[m] = '0; end
        pt_in = '1;
        repeat (3) @(negedge clk);
        chk("R1 sums in reset", 32'(sum_out), 0);
        chk("R1 flag in reset", 32'(config_error), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sums after reset", 32'(sum_out), 0);

        apply('0, '0, '0, '0);                 sweep("R4 all empty");
        apply(12'h001, 12'h008, 12'h800, 12'h040);
        sweep("R3 one term each");
        apply(12'h008, 12'h008, 12'h008, 12'h000);
        sweep("R7 shared term");
        apply(12'h801, 12'h000, 12'h002, 12'h001);
        sweep("R5 outside window");
        apply(12'h000, 12'h000, 12'h3F0, 12'h000);
        sweep("R6 over limit");
        apply(12'h03F, 12'h1FF, 12'hFFF, 12'hFF8);
        sweep("R6 full windows");
        apply(12'h021, 12'h104, 12'h900, 12'h0C0);
        sweep("R8 clean load clears");

        // R2: shift a new set without commit; nothing may change.
        pend[0] = 12'h002; pend[1] = 12'h010; pend[2] = 12'h400; pend[3] = 12'h800;
        send(1'b0);
        sweep("R2 shift without load");
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        for (int m = 0; m < MC; m++) mask[m] = pend[m];
        sweep("R2 load strobe commits");

        for (int k = 0; k < 6; k++) begin
            apply(12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom));
            sweep("R3 random masks");
        end
        apply(12'h000, 12'h0C0, 12'h000, 12'h000);
        sweep("R4 R8 partly empty");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule